// File: doc/BRIEF.md
# Destination Address Filter with Multicast Hash

This block decides whether an incoming Ethernet frame is meant for this station, working only from the destination address at the head of the frame. The address arrives one byte per valid cycle, first byte first, with a start marker on the first byte. While the bytes stream in, the block checks them against a programmed station address and against the all-ones broadcast address. It also runs the Ethernet CRC-32 over the same bytes, so that a group address can be tested against a 64-bit hash table.

For a group address the top six bits of the finished CRC pick one table bit, counted from the most significant end. One cycle after the last address byte the block raises a single-cycle done pulse with the accept decision beside it. A bypass input forces acceptance for the address being received, for receivers that want every frame.

Top module: `macf_filter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `done` and `accept` are 0.
- R2: A byte is taken when `addr_vld` is 1. A byte with `addr_start` 1 is byte 0 of a new address. `done` is 1 for exactly one cycle, in the cycle after the sixth taken byte.
- R3: The address FF-FF-FF-FF-FF-FF is accepted whatever the station address and hash table hold.
- R4: An address equal to `station_addr` is accepted. Received byte k is compared with `station_addr[8k+7:8k]`, and byte 0 is the first byte received.
- R5: When bit 0 of byte 0 (the group bit) is 1, the block runs the CRC over the six bytes. Each byte is taken LSB first, with reflected polynomial 0xEDB88320, seed 0xFFFFFFFF and a final inversion. The index is bits 31..26 of the result. The address is accepted when `hash_filter[63 - index]` is 1.
- R6: An address with group bit 0 that differs from `station_addr` is rejected, even when every hash table bit is 1.
- R7: When `pass_all` is 1 together with the sixth byte, the address is accepted.
- R8: Cycles with `addr_vld` 0 inside an address are skipped and change nothing. Bytes that arrive after a completed address without `addr_start` produce no `done`.
- R9: A byte with `addr_start` 1 in the middle of an address drops the partial address and begins a new one.
- R10: `accept` is 0 in every cycle in which `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_vld | input | 1 | Byte on `addr_byte` is valid |
| addr_start | input | 1 | Valid byte is byte 0 of an address |
| addr_byte | input | 8 | Destination address byte |
| station_addr | input | 48 | Programmed station address, byte 0 in bits 7..0 |
| hash_filter | input | 64 | Multicast hash table |
| pass_all | input | 1 | Force acceptance of the current address |
| done | output | 1 | Decision pulse, one cycle after the last byte |
| accept | output | 1 | Address accepted, qualified by `done` |

## Verification
The assertions assume that `addr_start` comes only with `addr_vld`, and that one address completes no sooner than six cycles after the previous one, which follows from the six-byte length. The assertions also assume that `pass_all` is held steady while the last byte is taken. The bench drives every byte on the falling edge with the start marker only on valid bytes. It keeps `pass_all` steady for the whole of each address, and it mixes random gaps between bytes with back-to-back runs. Random addresses are weighted toward station matches, broadcast and group addresses, so that every accept path is taken often.

// File: rtl/macf_pkg.sv
package macf_pkg;
   localparam int unsigned CRC_W = 32;
   localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB8_8320;
   localparam logic [CRC_W-1:0] CRC_SEED      = 32'hFFFF_FFFF;
endpackage

// File: rtl/macf_crc_step.sv
module macf_crc_step
   import macf_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              take,
   input  logic [DATA_W-1:0] din,
   output logic [CRC_W-1:0]  upd_o
);
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] chain [0:DATA_W];

   assign chain[0] = restart ? CRC_SEED : crc_q;

   // one reflected LFSR step per input bit, LSB first
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      logic fb;
      assign fb = chain[b][0] ^ din[b];
      assign chain[b+1] = (chain[b] >> 1) ^ ({CRC_W{fb}} & CRC_POLY_REFL);
   end

   assign upd_o = chain[DATA_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    crc_q <= CRC_SEED;
      else if (take) crc_q <= chain[DATA_W];
   end
endmodule

// File: rtl/macf_addr_track.sv
module macf_addr_track #(
   parameter int unsigned NBYTES = 6,
   localparam int unsigned CNT_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                vld,
   input  logic                start,
   input  logic [7:0]          data,
   input  logic [8*NBYTES-1:0] station,
   output logic                take_o,
   output logic                last_o,
   output logic                phys_o,
   output logic                bcast_o,
   output logic                group_o
);
   logic [CNT_W-1:0] cnt_q, pos;
   logic             active_q, phys_q, bc_q, grp_q;

   assign pos     = start ? '0 : cnt_q;
   assign take_o  = vld & (start | active_q);
   assign last_o  = take_o & (pos == CNT_W'(NBYTES-1));
   assign phys_o  = (start | phys_q) & (data == station[8*pos +: 8]);
   assign bcast_o = (start | bc_q) & (data == 8'hFF);
   assign group_o = start ? data[0] : grp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
         phys_q   <= 1'b0;
         bc_q     <= 1'b0;
         grp_q    <= 1'b0;
      end else if (take_o) begin
         phys_q <= phys_o;
         bc_q   <= bcast_o;
         grp_q  <= group_o;
         if (last_o) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
         end else begin
            cnt_q    <= pos + 1'b1;
            active_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/macf_filter.sv
module macf_filter
   import macf_pkg::*;
#(
   parameter int unsigned NBYTES    = 6,
   parameter int unsigned HASH_BITS = 6,
   localparam int unsigned ADDR_W   = 8 * NBYTES,
   localparam int unsigned FILT_W   = 1 << HASH_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_vld,
   input  logic              addr_start,
   input  logic [7:0]        addr_byte,
   input  logic [ADDR_W-1:0] station_addr,
   input  logic [FILT_W-1:0] hash_filter,
   input  logic              pass_all,
   output logic              done,
   output logic              accept
);
   if (NBYTES < 2)     $error("macf_filter: NBYTES must be at least 2");
   if (HASH_BITS > 16) $error("macf_filter: HASH_BITS must not exceed 16");

   logic             take, last, phys_hit, bc_hit, grp;
   logic [CRC_W-1:0] crc_upd, crc_fin;
   logic             hash_hit, decide;
   logic             done_q, acc_q;

   macf_addr_track #(.NBYTES(NBYTES)) u_track (
      .clk(clk), .rst_n(rst_n), .vld(addr_vld), .start(addr_start),
      .data(addr_byte), .station(station_addr), .take_o(take),
      .last_o(last), .phys_o(phys_hit), .bcast_o(bc_hit), .group_o(grp)
   );

   macf_crc_step #(.DATA_W(8)) u_crc (
      .clk(clk), .rst_n(rst_n), .restart(addr_start), .take(take),
      .din(addr_byte), .upd_o(crc_upd)
   );

   assign crc_fin = ~crc_upd;

   if (HASH_BITS == 0) begin : g_no_hash
      assign hash_hit = hash_filter[0];
   end else begin : g_hash
      logic [HASH_BITS-1:0] idx;
      assign idx = crc_fin[CRC_W-1 -: HASH_BITS];
      // table counted from its top bit: position FILT_W-1-idx
      assign hash_hit = hash_filter[~idx];
   end

   assign decide = pass_all | bc_hit | phys_hit | (grp & hash_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         acc_q  <= 1'b0;
      end else begin
         done_q <= last;
         acc_q  <= last & decide;
      end
   end

   assign done   = done_q;
   assign accept = acc_q;
endmodule

// File: rtl/macf_filter_chk.sv
module macf_filter_chk (
   input logic clk,
   input logic rst_n,
   input logic addr_vld,
   input logic addr_start,
   input logic pass_all,
   input logic done,
   input logic accept
);
   // R1: outputs quiet during reset
   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r1 : assert (!done && !accept)
            else $error("p_reset_quiet_r1");
      end
   end

   // R2: done is a single-cycle pulse
   p_done_pulse_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2: done always follows a taken byte
   p_done_after_byte_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(addr_vld));

   // R7: bypass on the last byte forces acceptance
   p_bypass_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(pass_all)) |-> accept);

   // R10: accept qualified by done
   p_accept_qual_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> done);
endmodule

bind macf_filter macf_filter_chk u_chk (
   .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .addr_start(addr_start),
   .pass_all(pass_all), .done(done), .accept(accept)
);

// File: tb/macf_filter_tb.sv
module macf_filter_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr_vld = 1'b0, addr_start = 1'b0, pass_all = 1'b0;
   logic [7:0]  addr_byte = '0;
   logic [47:0] station_addr = '0;
   logic [63:0] hash_filter = '0;
   logic        done, accept;

   int checks = 0, errors = 0, cyc = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   macf_filter u_dut (
      .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .addr_start(addr_start),
      .addr_byte(addr_byte), .station_addr(station_addr),
      .hash_filter(hash_filter), .pass_all(pass_all),
      .done(done), .accept(accept)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         finished = 1;
         errors++;
         $display("FAIL watchdog expired act=%0d exp=0", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_crc(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int k = 0; k < 6; k++)
         for (int b = 0; b < 8; b++) begin
            logic fb = c[0] ^ a[8*k+b];
            c = c >> 1;
            if (fb) c = c ^ 32'hEDB8_8320;
         end
      return ~c;
   endfunction

   function automatic int ref_idx(input logic [47:0] a);
      logic [31:0] c = ref_crc(a);
      return int'(c[31:26]);
   endfunction

   function automatic bit ref_accept(input logic [47:0] a, input logic [47:0] st,
                                     input logic [63:0] f, input bit pa);
      if (pa) return 1;
      if (a == 48'hFFFF_FFFF_FFFF) return 1;
      if (a == st) return 1;
      if (a[0] && f[63 - ref_idx(a)]) return 1;
      return 0;
   endfunction

   task automatic send_addr(input logic [47:0] a, input bit gaps, input string req);
      bit exp = ref_accept(a, station_addr, hash_filter, pass_all);
      for (int k = 0; k < 6; k++) begin
         if (gaps) begin
            int g = $urandom % 3;
            for (int i = 0; i < g; i++) begin
               @(negedge clk);
               addr_vld = 0; addr_start = 0; addr_byte = $urandom;
            end
         end
         @(negedge clk);
         addr_vld = 1; addr_start = (k == 0); addr_byte = a[8*k +: 8];
      end
      @(negedge clk);
      addr_vld = 0; addr_start = 0;
      check(done == 1'b1, {req, " R2 done after sixth byte"}, done, 1);
      check(accept == exp, {req, " accept"}, accept, exp);
      @(negedge clk);
      check(done == 1'b0 && accept == 1'b0, {req, " R2 R10 single pulse"}, {done, accept}, 0);
   endtask

   initial begin
      logic [47:0] a;
      int idx;
      void'($urandom(32'd2718));
      station_addr = 48'h6655_4433_2210;
      #(3*CLK_PERIOD + 2);
      check(done == 0 && accept == 0, "R1 reset outputs", {done, accept}, 0);
      @(negedge clk); rst_n = 1;
      check(done == 0 && accept == 0, "R1 after reset", {done, accept}, 0);

      // R3 broadcast with empty table and other station
      hash_filter = '0;
      send_addr(48'hFFFF_FFFF_FFFF, 0, "R3");
      // R4 station match
      send_addr(station_addr, 1, "R4");
      // R6 individual mismatch, full table
      hash_filter = '1;
      send_addr(48'h6655_4433_2212, 0, "R6");
      // R5 one-hot hash hit and its complement miss
      a = 48'h3412_0000_5E01;
      idx = ref_idx(a);
      hash_filter = 64'd1 << (63 - idx);
      send_addr(a, 0, "R5 hit");
      hash_filter = ~(64'd1 << (63 - idx));
      send_addr(a, 1, "R5 miss");
      // R7 bypass
      hash_filter = '0; pass_all = 1;
      send_addr(48'h0102_0304_0506, 0, "R7");
      pass_all = 0;

      // R8 stray bytes without start produce no done
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         addr_vld = 1; addr_start = 0; addr_byte = 8'hFF;
         check(done == 0, "R8 stray byte no done", done, 0);
      end
      @(negedge clk); addr_vld = 0;
      check(done == 0, "R8 stray tail", done, 0);

      // R9 restart mid-address
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         addr_vld = 1; addr_start = (k == 0); addr_byte = 8'hAA;
         check(done == 0, "R9 partial no done", done, 0);
      end
      send_addr(station_addr, 0, "R9 restart");

      // random mix
      for (int n = 0; n < 300; n++) begin
         int m = $urandom % 4;
         station_addr = {$urandom, $urandom} & ~48'h1;
         hash_filter  = {$urandom, $urandom};
         pass_all     = ($urandom % 8) == 0;
         a = {$urandom, $urandom};
         case (m)
            1: a = station_addr;
            2: a = 48'hFFFF_FFFF_FFFF;
            3: a[0] = 1'b1;
            default: ;
         endcase
         send_addr(a, ($urandom % 2) == 1, "R3 R4 R5 R6 R7 random");
      end

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule